// File: doc/BRIEF.md
# Serial Bitmap Palette and Pixel Loader

This block sits behind a UART byte receiver and unpacks an uncompressed 8-bit indexed bitmap as it arrives. The leading file header is thrown away. The colour table that follows is turned into writes on a palette DAC port, which has a two-bit register select, an 8-bit data bus and an active-low write strobe. All remaining bytes are pixel indices. Each one is handed to a frame memory as a write request, with a row and column address and a valid/ready handshake.

The received stream has no backpressure, so the block has to keep up with the byte rate. A serial link gives thousands of clock cycles between bytes. The block assumes at least one full palette-entry write burst between two reserved bytes, and that the memory takes each pixel before the next pixel byte arrives. When the last pixel has been taken, a sticky completion flag rises so that the display timing can start.

Top module: `bmpl_loader`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `dac_wr_n` is 1 and `mem_req` and `load_done` are 0.
- R2: The first HDR_BYTES received bytes cause no DAC strobe and no memory request.
- R3: After the last header byte, exactly two DAC writes follow in this order. The first writes 0xFF with `dac_rs` = 2'b10, where bit 1 is the upper select line, to set the pixel mask. The second writes 0x00 with `dac_rs` = 2'b00 to clear the colour index.
- R4: Each palette entry arrives as four bytes in the order blue, green, red, unused. On the unused byte the block issues three writes with `dac_rs` = 2'b01, carrying red, green and blue in that order. Each value is the received byte shifted right by 8−COLOR_BITS, which is 2 by default. The unused byte is never written.
- R5: For every DAC write, `dac_rs` and `dac_data` settle at least SETUP cycles before `dac_wr_n` falls. `dac_wr_n` then stays low for exactly PULSE cycles, and both buses hold steady while it is low.
- R6: The k-th pixel byte, counting from 0, is requested at `mem_row` = k / COLS and `mem_col` = k mod COLS, with `mem_data` equal to the byte. The column runs first.
- R7: `mem_req` stays high with row, column and data unchanged until it is sampled together with `mem_ready`. It drops in the next cycle.
- R8: A pixel byte sampled at a clock edge raises `mem_req` at that edge, which is one cycle of latency.
- R9: `load_done` rises in the cycle after the ROWS·COLS-th pixel is accepted and stays high.
- R10: Once `load_done` is high, further received bytes cause no memory request and no DAC strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle pulse: a received byte is on rx_data |
| rx_data | input | 8 | Received byte |
| dac_rs | output | 2 | Palette port register select, bit 1 = upper line |
| dac_data | output | 8 | Palette port data bus |
| dac_wr_n | output | 1 | Palette port write strobe, active low |
| mem_req | output | 1 | Pixel write request |
| mem_ready | input | 1 | Memory accepts the pending request |
| mem_row | output | ROW_W | Pixel row address |
| mem_col | output | COL_W | Pixel column address |
| mem_data | output | 8 | Pixel byte |
| load_done | output | 1 | Whole image stored, sticky |

## Verification
A pixel request is due one edge after its byte is sampled. The bench sends each byte at a falling edge and reads `mem_req` at the next falling edge. For a DAC write, the bus changes at the issue edge, the strobe falls SETUP edges later and rises PULSE edges after that. A falling-edge monitor measures these gaps directly and logs every write, so the checks compare counts and do not wait for fixed cycles. The completion flag is read at the first falling edge after the edge at which the final request was accepted.

// File: rtl/bmpl_pkg.sv
// Shared types for the bitmap loader.
package bmpl_pkg;

    // Loader progress through the incoming file
    typedef enum logic [1:0] {
        PH_HDR = 2'd0,
        PH_PAL = 2'd1,
        PH_PIX = 2'd2,
        PH_END = 2'd3
    } phase_t;

    // One write to the palette port
    typedef struct packed {
        logic [1:0] sel;
        logic [7:0] val;
    } dac_wr_t;

    // Register-select codes; bit 1 drives the upper select line
    localparam logic [1:0] SEL_INDEX = 2'b00;
    localparam logic [1:0] SEL_COLOR = 2'b01;
    localparam logic [1:0] SEL_MASK  = 2'b10;

endpackage

// File: rtl/bmpl_phase_ctl.sv
// Phase controller: counts header bytes, sorts palette bytes by position
// and hands complete entries on. Assumes rx_valid is a one-cycle pulse.
module bmpl_phase_ctl
    import bmpl_pkg::*;
#(
    parameter int HDR_BYTES   = 54,
    parameter int PAL_ENTRIES = 256,
    parameter int COLOR_BITS  = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_valid,
    input  logic [COLOR_BITS-1:0] color_in,
    input  logic                  done,
    output logic                  load_init,
    output logic                  load_entry,
    output logic [COLOR_BITS-1:0] red,
    output logic [COLOR_BITS-1:0] green,
    output logic [COLOR_BITS-1:0] blue,
    output logic                  pix_en
);
    localparam int HW = $clog2(HDR_BYTES + 1);
    localparam int EW = $clog2(PAL_ENTRIES + 1);

    phase_t          phase_q;
    logic [HW-1:0]   hdr_cnt_q;
    logic [EW-1:0]   ent_cnt_q;
    logic [1:0]      pos_q;

    // Phase and byte-position bookkeeping for each received byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_HDR;
            hdr_cnt_q  <= '0;
            ent_cnt_q  <= '0;
            pos_q      <= 2'd0;
            load_init  <= 1'b0;
            load_entry <= 1'b0;
            red        <= '0;
            green      <= '0;
            blue       <= '0;
        end else begin
            load_init  <= 1'b0;
            load_entry <= 1'b0;
            case (phase_q)
                PH_HDR: if (rx_valid) begin
                    if (hdr_cnt_q == HW'(HDR_BYTES - 1)) begin
                        phase_q   <= PH_PAL;
                        load_init <= 1'b1;
                    end else begin
                        hdr_cnt_q <= hdr_cnt_q + 1'b1;
                    end
                end
                PH_PAL: if (rx_valid) begin
                    pos_q <= pos_q + 2'd1;
                    case (pos_q)
                        2'd0:    blue  <= color_in;
                        2'd1:    green <= color_in;
                        2'd2:    red   <= color_in;
                        default: begin
                            load_entry <= 1'b1;
                            if (ent_cnt_q == EW'(PAL_ENTRIES - 1)) begin
                                phase_q <= PH_PIX;
                            end else begin
                                ent_cnt_q <= ent_cnt_q + 1'b1;
                            end
                        end
                    endcase
                end
                PH_PIX: if (done) phase_q <= PH_END;
                default: phase_q <= PH_END;
            endcase
        end
    end

    // Pixel routing is enabled only in the pixel phase
    always_comb pix_en = (phase_q == PH_PIX);

endmodule

// File: rtl/bmpl_wr_queue.sv
// Holds up to three pending palette-port writes and issues them in order.
// Assumes a new load never arrives before the previous batch has drained.
module bmpl_wr_queue
    import bmpl_pkg::*;
#(
    parameter int COLOR_BITS = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_init,
    input  logic                  load_entry,
    input  logic [COLOR_BITS-1:0] red,
    input  logic [COLOR_BITS-1:0] green,
    input  logic [COLOR_BITS-1:0] blue,
    input  logic                  busy,
    output logic                  go,
    output dac_wr_t               wr_out
);
    localparam int SLOTS = 3;

    dac_wr_t    slot_q [SLOTS];
    logic [1:0] pend_q;
    logic [1:0] idx_q;
    logic [7:0] red_w, green_w, blue_w;

    // Widen the truncated colours back onto the 8-bit bus
    generate
        if (COLOR_BITS == 8) begin : g_full
            always_comb begin
                red_w   = red;
                green_w = green;
                blue_w  = blue;
            end
        end else begin : g_pad
            always_comb begin
                red_w   = {{(8 - COLOR_BITS){1'b0}}, red};
                green_w = {{(8 - COLOR_BITS){1'b0}}, green};
                blue_w  = {{(8 - COLOR_BITS){1'b0}}, blue};
            end
        end
    endgenerate

    // Issue the next slot whenever the strobe generator is free
    always_comb begin
        go     = (pend_q != 2'd0) && !busy;
        wr_out = slot_q[idx_q];
    end

    // Load batches and step through them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 2'd0;
            idx_q  <= 2'd0;
            for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
        end else if (load_init) begin
            slot_q[0] <= '{sel: SEL_MASK,  val: 8'hFF};
            slot_q[1] <= '{sel: SEL_INDEX, val: 8'h00};
            pend_q    <= 2'd2;
            idx_q     <= 2'd0;
        end else if (load_entry) begin
            slot_q[0] <= '{sel: SEL_COLOR, val: red_w};
            slot_q[1] <= '{sel: SEL_COLOR, val: green_w};
            slot_q[2] <= '{sel: SEL_COLOR, val: blue_w};
            pend_q    <= 2'd3;
            idx_q     <= 2'd0;
        end else if (go) begin
            pend_q <= pend_q - 2'd1;
            idx_q  <= idx_q + 2'd1;
        end
    end

endmodule

// File: rtl/bmpl_dac_strobe.sv
// Drives one palette-port write: bus set at issue, strobe low after SETUP
// cycles for PULSE cycles, then at least HOLD idle cycles. SETUP must be >= 1.
module bmpl_dac_strobe
    import bmpl_pkg::*;
#(
    parameter int SETUP = 1,
    parameter int PULSE = 3,
    parameter int HOLD  = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  dac_wr_t    wr_in,
    output logic       busy,
    output logic [1:0] dac_rs,
    output logic [7:0] dac_data,
    output logic       dac_wr_n
);
    localparam int SPAN = SETUP + PULSE + HOLD;
    localparam int CW   = $clog2(SPAN + 1);

    logic [CW-1:0] cnt_q, cnt_n;
    logic          busy_q, busy_n;
    logic          low_n;

    // Next-state of the write window counter
    always_comb begin
        busy_n = busy_q;
        cnt_n  = cnt_q;
        if (busy_q) begin
            if (cnt_q == CW'(SPAN - 1)) busy_n = 1'b0;
            else                        cnt_n  = cnt_q + 1'b1;
        end else if (go) begin
            busy_n = 1'b1;
            cnt_n  = '0;
        end
        low_n = busy_n && (cnt_n >= CW'(SETUP)) && (cnt_n < CW'(SETUP + PULSE));
    end

    // Register counter, strobe and the bus values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            cnt_q    <= '0;
            dac_wr_n <= 1'b1;
            dac_rs   <= 2'b00;
            dac_data <= 8'h00;
        end else begin
            busy_q   <= busy_n;
            cnt_q    <= cnt_n;
            dac_wr_n <= ~low_n;
            if (!busy_q && go) begin
                dac_rs   <= wr_in.sel;
                dac_data <= wr_in.val;
            end
        end
    end

    // Strobe generator occupancy
    always_comb busy = busy_q;

endmodule

// File: rtl/bmpl_pix_writer.sv
// Turns pixel bytes into frame-memory write requests, column first.
// Assumes each request is accepted before the next pixel byte arrives.
module bmpl_pix_writer #(
    parameter int COLS  = 512,
    parameter int ROWS  = 512,
    parameter int COL_W = $clog2(COLS),
    parameter int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             mem_ready,
    output logic             mem_req,
    output logic [ROW_W-1:0] mem_row,
    output logic [COL_W-1:0] mem_col,
    output logic [7:0]       mem_data,
    output logic             done
);
    logic accept;

    // Handshake completion
    always_comb accept = mem_req && mem_ready;

    // Request capture, address stepping and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req  <= 1'b0;
            mem_row  <= '0;
            mem_col  <= '0;
            mem_data <= 8'h00;
            done     <= 1'b0;
        end else if (accept) begin
            mem_req <= 1'b0;
            if (mem_col == COL_W'(COLS - 1)) begin
                mem_col <= '0;
                if (mem_row == ROW_W'(ROWS - 1)) done <= 1'b1;
                else                             mem_row <= mem_row + 1'b1;
            end else begin
                mem_col <= mem_col + 1'b1;
            end
        end else if (en && !done && rx_valid && !mem_req) begin
            mem_req  <= 1'b1;
            mem_data <= rx_data;
        end
    end

endmodule

// File: rtl/bmpl_loader.sv
// Top: splits a serial bitmap stream into header, palette and pixels.
// Assumes bytes are spaced far enough apart for the palette writes to drain.
module bmpl_loader #(
    parameter int HDR_BYTES   = 54,
    parameter int PAL_ENTRIES = 256,
    parameter int COLS        = 512,
    parameter int ROWS        = 512,
    parameter int COLOR_BITS  = 6,
    parameter int SETUP       = 1,
    parameter int PULSE       = 3,
    parameter int HOLD        = 1,
    parameter int COL_W       = $clog2(COLS),
    parameter int ROW_W       = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    output logic [1:0]       dac_rs,
    output logic [7:0]       dac_data,
    output logic             dac_wr_n,
    output logic             mem_req,
    input  logic             mem_ready,
    output logic [ROW_W-1:0] mem_row,
    output logic [COL_W-1:0] mem_col,
    output logic [7:0]       mem_data,
    output logic             load_done
);
    import bmpl_pkg::*;

    logic                  load_init, load_entry, pix_en, go, busy;
    logic [COLOR_BITS-1:0] red, green, blue;
    dac_wr_t               wr_next;

    bmpl_phase_ctl #(
        .HDR_BYTES  (HDR_BYTES),
        .PAL_ENTRIES(PAL_ENTRIES),
        .COLOR_BITS (COLOR_BITS)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .color_in  (rx_data[7 -: COLOR_BITS]),
        .done      (load_done),
        .load_init (load_init),
        .load_entry(load_entry),
        .red       (red),
        .green     (green),
        .blue      (blue),
        .pix_en    (pix_en)
    );

    bmpl_wr_queue #(
        .COLOR_BITS(COLOR_BITS)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_init (load_init),
        .load_entry(load_entry),
        .red       (red),
        .green     (green),
        .blue      (blue),
        .busy      (busy),
        .go        (go),
        .wr_out    (wr_next)
    );

    bmpl_dac_strobe #(
        .SETUP(SETUP),
        .PULSE(PULSE),
        .HOLD (HOLD)
    ) u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .wr_in   (wr_next),
        .busy    (busy),
        .dac_rs  (dac_rs),
        .dac_data(dac_data),
        .dac_wr_n(dac_wr_n)
    );

    bmpl_pix_writer #(
        .COLS (COLS),
        .ROWS (ROWS),
        .COL_W(COL_W),
        .ROW_W(ROW_W)
    ) u_pix (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (pix_en),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .mem_ready(mem_ready),
        .mem_req  (mem_req),
        .mem_row  (mem_row),
        .mem_col  (mem_col),
        .mem_data (mem_data),
        .done     (load_done)
    );

endmodule

// File: rtl/bmpl_loader_chk.sv
// Protocol checker for the loader, bound to every bmpl_loader instance.
module bmpl_loader_chk #(
    parameter int COLS  = 512,
    parameter int PULSE = 3,
    parameter int COL_W = 9,
    parameter int ROW_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       dac_rs,
    input logic [7:0]       dac_data,
    input logic             dac_wr_n,
    input logic             mem_req,
    input logic             mem_ready,
    input logic [ROW_W-1:0] mem_row,
    input logic [COL_W-1:0] mem_col,
    input logic [7:0]       mem_data,
    input logic             load_done
);
    logic [7:0] low_cnt;

    // Count consecutive low strobe cycles
    always_ff @(posedge clk) begin
        if (!rst_n)         low_cnt <= 8'd0;
        else if (!dac_wr_n) low_cnt <= low_cnt + 8'd1;
        else                low_cnt <= 8'd0;
    end

    // R5
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_wr_n) |-> (low_cnt == 8'(PULSE)));

    // R5
    strobe_bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_wr_n && $past(!dac_wr_n)) |-> ($stable(dac_data) && $stable(dac_rs)));

    // R4
    strobe_sel_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_wr_n |-> (dac_rs != 2'b11));

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_row) && $stable(mem_col) && $stable(mem_data)));

    // R6
    col_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && mem_col == COL_W'(COLS - 1)) |=> (mem_col == '0));

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> load_done);

    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> !mem_req);

endmodule

bind bmpl_loader bmpl_loader_chk #(
    .COLS (COLS),
    .PULSE(PULSE),
    .COL_W(COL_W),
    .ROW_W(ROW_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dac_rs   (dac_rs),
    .dac_data (dac_data),
    .dac_wr_n (dac_wr_n),
    .mem_req  (mem_req),
    .mem_ready(mem_ready),
    .mem_row  (mem_row),
    .mem_col  (mem_col),
    .mem_data (mem_data),
    .load_done(load_done)
);

// File: tb/test_bmpl_loader.sv
module test_bmpl_loader;
    localparam int HDR   = 6;
    localparam int PAL   = 4;
    localparam int COLS  = 8;
    localparam int ROWS  = 4;
    localparam int CB    = 6;
    localparam int SETUP = 2;
    localparam int PULSE = 3;
    localparam int HOLD  = 1;
    localparam int CW    = $clog2(COLS);
    localparam int RW    = $clog2(ROWS);
    localparam int NPIX  = COLS * ROWS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = 8'h00;
    logic [1:0]    dac_rs;
    logic [7:0]    dac_data;
    logic          dac_wr_n;
    logic          mem_req;
    logic          mem_ready = 1'b0;
    logic [RW-1:0] mem_row;
    logic [CW-1:0] mem_col;
    logic [7:0]    mem_data;
    logic          load_done;

    int  checks = 0;
    int  fails  = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    bmpl_loader #(
        .HDR_BYTES(HDR), .PAL_ENTRIES(PAL), .COLS(COLS), .ROWS(ROWS),
        .COLOR_BITS(CB), .SETUP(SETUP), .PULSE(PULSE), .HOLD(HOLD)
    ) i_bmpl_loader (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .dac_rs(dac_rs), .dac_data(dac_data), .dac_wr_n(dac_wr_n),
        .mem_req(mem_req), .mem_ready(mem_ready), .mem_row(mem_row),
        .mem_col(mem_col), .mem_data(mem_data), .load_done(load_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Palette-port write log, filled by a falling-edge monitor
    logic [9:0] wl_bus   [64];
    int         wl_low   [64];
    int         wl_setup [64];
    bit         wl_ok    [64];
    int         wn = 0;
    logic [9:0] prev_bus = '0;
    logic       prev_wr = 1'b1;
    int         stab = 0;
    int         low_len = 0;
    int         setup_v = 0;
    bit         low_ok = 1'b1;
    logic [9:0] low_bus = '0;

    always @(negedge clk) begin
        logic [9:0] cur;
        cur = {dac_rs, dac_data};
        if (cur == prev_bus) stab++;
        else                 stab = 0;
        if (prev_wr && !dac_wr_n) begin
            setup_v = stab; low_bus = cur; low_len = 1; low_ok = 1'b1;
        end else if (!dac_wr_n) begin
            low_len++;
            if (cur != low_bus) low_ok = 1'b0;
        end else if (!prev_wr && dac_wr_n && wn < 64) begin
            wl_bus[wn] = low_bus; wl_low[wn] = low_len;
            wl_setup[wn] = setup_v; wl_ok[wn] = low_ok; wn++;
        end
        prev_bus = cur;
        prev_wr  = dac_wr_n;
    end

    // Memory responder and request log: stalls 0..2 cycles per request
    logic [RW-1:0] pl_row  [64];
    logic [CW-1:0] pl_col  [64];
    logic [7:0]    pl_data [64];
    bit            pl_done [64];
    int            pn = 0;
    int            stall = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ready = 1'b0;
            stall = 0;
        end else if (mem_ready) begin
            mem_ready = 1'b0;
        end else if (mem_req) begin
            if (stall >= pn % 3) begin
                if (pn < 64) begin
                    pl_row[pn] = mem_row; pl_col[pn] = mem_col;
                    pl_data[pn] = mem_data; pl_done[pn] = load_done;
                end
                pn++;
                stall = 0;
                mem_ready = 1'b1;
            end else begin
                stall++;
            end
        end
    end

    task automatic send(input logic [7:0] b, input int gap);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    function automatic logic [7:0] pal_b(input int e); return 8'(e * 37 + 5);   endfunction
    function automatic logic [7:0] pal_g(input int e); return 8'(e * 11 + 200); endfunction
    function automatic logic [7:0] pal_r(input int e); return 8'(e * 53 + 17);  endfunction
    function automatic logic [7:0] pix(input int k);   return 8'(k * 7 + 3);    endfunction

    task automatic check_write(input int i, input logic [1:0] sel,
                               input logic [7:0] val, input string req);
        chk(wl_bus[i][9:8] == sel, req, $sformatf("write %0d select", i), int'(wl_bus[i][9:8]), int'(sel));
        chk(wl_bus[i][7:0] == val, req, $sformatf("write %0d data", i), int'(wl_bus[i][7:0]), int'(val));
        chk(wl_low[i] == PULSE, "R5", $sformatf("write %0d strobe width", i), wl_low[i], PULSE);
        chk(wl_setup[i] >= SETUP, "R5", $sformatf("write %0d setup", i), wl_setup[i], SETUP);
        chk(wl_ok[i], "R5", $sformatf("write %0d bus steady", i), int'(wl_ok[i]), 1);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(dac_wr_n == 1'b1, "R1", "strobe in reset", int'(dac_wr_n), 1);
        chk(mem_req == 1'b0, "R1", "request in reset", int'(mem_req), 0);
        chk(load_done == 1'b0, "R1", "done in reset", int'(load_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dac_wr_n == 1'b1 && mem_req == 1'b0 && load_done == 1'b0, "R1",
            "outputs after release", int'({dac_wr_n, mem_req, load_done}), 4);
    endtask

    task automatic t_header();
        for (int i = 0; i < HDR - 1; i++) send(8'hA0 + 8'(i), 3);
        chk(wn == 0, "R2", "strobes during header", wn, 0);
        chk(pn == 0 && mem_req == 1'b0, "R2", "requests during header", pn, 0);
        send(8'hA0 + 8'(HDR - 1), 30);
        chk(wn == 2, "R3", "setup write count", wn, 2);
        check_write(0, 2'b10, 8'hFF, "R3");
        check_write(1, 2'b00, 8'h00, "R3");
    endtask

    task automatic t_palette();
        for (int e = 0; e < PAL; e++) begin
            send(pal_b(e), 2);
            send(pal_g(e), 2);
            send(pal_r(e), 2);
            send(8'h5A, 30);
        end
        chk(wn == 2 + 3 * PAL, "R4", "palette write count", wn, 2 + 3 * PAL);
        for (int e = 0; e < PAL; e++) begin
            check_write(2 + 3 * e, 2'b01, pal_r(e) >> (8 - CB), "R4");
            check_write(3 + 3 * e, 2'b01, pal_g(e) >> (8 - CB), "R4");
            check_write(4 + 3 * e, 2'b01, pal_b(e) >> (8 - CB), "R4");
        end
        chk(pn == 0, "R4", "requests during palette", pn, 0);
    endtask

    task automatic t_pixels();
        for (int k = 0; k < NPIX; k++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = pix(k);
            @(negedge clk);
            rx_valid = 1'b0;
            chk(mem_req == 1'b1 || pn > k, "R8", $sformatf("pixel %0d request latency", k), int'(mem_req), 1);
            repeat (6) @(negedge clk);
        end
        chk(pn == NPIX, "R6", "accepted pixels", pn, NPIX);
        for (int k = 0; k < NPIX && k < 64; k++) begin
            chk(int'(pl_row[k]) == k / COLS, "R6", $sformatf("pixel %0d row", k), int'(pl_row[k]), k / COLS);
            chk(int'(pl_col[k]) == k % COLS, "R6", $sformatf("pixel %0d column", k), int'(pl_col[k]), k % COLS);
            chk(pl_data[k] == pix(k), "R7", $sformatf("pixel %0d data", k), int'(pl_data[k]), int'(pix(k)));
            chk(pl_done[k] == 1'b0, "R9", $sformatf("done early at pixel %0d", k), int'(pl_done[k]), 0);
        end
        chk(load_done == 1'b1, "R9", "done after last pixel", int'(load_done), 1);
        chk(mem_req == 1'b0, "R7", "request dropped after accept", int'(mem_req), 0);
    endtask

    task automatic t_after_done();
        int w0;
        int p0;
        w0 = wn;
        p0 = pn;
        for (int i = 0; i < 4; i++) begin
            send(8'hC3 + 8'(i), 0);
            chk(mem_req == 1'b0, "R10", "request after done", int'(mem_req), 0);
            repeat (10) @(negedge clk);
        end
        chk(wn == w0, "R10", "strobes after done", wn, w0);
        chk(pn == p0, "R10", "requests after done", pn, p0);
        chk(load_done == 1'b1, "R9", "done stays high", int'(load_done), 1);
    endtask

    initial begin
        t_reset();
        t_header();
        t_palette();
        t_pixels();
        t_after_done();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule